// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels, each with a low and a high count byte. A channel advances on every clock, or on each falling edge of its external count pin, while its run enable is high. A three-bit mode code per channel picks one of five behaviours. The first is a 13-bit counter whose low five bits act as a divide-by-32 prescaler for the high byte. The others are a plain 16-bit counter, an 8-bit counter that reloads from the high byte, a split mode and an 8-bit PWM generator with a 256-count period.

In split mode, channel 0 becomes two independent 8-bit counters. Its high half runs from the clock under channel 1's run enable and owns channel 1's overflow flag. While the split is active, channel 1 keeps counting and reports its overflows only on a tick output. A channel placed in split mode itself on the channel 1 side simply freezes.

Each channel has a sticky overflow flag with a clear input. It can also turn its count pin into an output. In that case the output starts high and inverts on every overflow event of the channel. Software-style access uses a byte write port and a combinational read port, each addressed by a two-bit selector.

Top module: `tmr_pair`

## Requirements
- R1: After reset all four count bytes read 0, both flags are 0, t1_tick is 0, both pin_oe bits are 0 and both pin_out bits are 1.
- R2: A running channel (run_en bit high) advances once per clock when its ext_sel bit is 0. When ext_sel is 1, it advances once per falling edge of its pin_in bit, counted after a two-flop synchronizer, and does not advance while its tog_en bit makes the pin an output. With run_en low the count holds.
- R3: Mode code 0: each advance increments bits [4:0] of the low byte. On their wrap from 31 the high byte increments. The step from high byte 0xFF with prescaler 31 is an overflow, and low-byte bits [7:5] never change by counting.
- R4: Mode code 1: {high, low} is a 16-bit counter, and the step from 0xFFFF to 0x0000 is an overflow.
- R5: Mode code 2: the low byte increments. An advance at 0xFF loads the high byte into the low byte instead and is an overflow. The high byte is not changed by counting.
- R6: Mode code 3 on channel 0: the low byte is an 8-bit counter under channel 0's controls and its wrap sets flag 0. The high byte increments on every clock while run_en[1] is high, and its wrap from 0xFF sets flag 1.
- R7: Mode code 3 on channel 1, and codes 4, 5 and 7 on either channel, hold the count and produce no overflow.
- R8: t1_tick pulses for one cycle, one clock after each channel 1 overflow. While channel 0 is in mode 3, channel 1 overflows do not set flag 1.
- R9: Mode code 6: the low byte counts freely with period 256 and its wrap is an overflow. pin_oe is 1, and pin_out is 1 exactly while the low byte is below the high byte.
- R10: With tog_en set, outside mode 6, pin_oe is 1 and pin_out reads 1 from the first cycle of enabling. It then inverts on each event that sets the channel's flag.
- R11: A flag stays set until its flag_clr bit is high. A set event in the same cycle as a clear leaves the flag set.
- R12: The selector code for wr_sel and rd_sel is 0 = channel 0 low, 1 = channel 0 high, 2 = channel 1 low, 3 = channel 1 high. A write lands at the next clock, and the written channel does not count during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 2 | Run enable per channel |
| ext_sel | input | 2 | 1 = count pin falling edges, 0 = count clocks |
| tog_en | input | 2 | Turns the channel pin into an overflow toggle output |
| mode_t0 | input | 3 | Mode code of channel 0 |
| mode_t1 | input | 3 | Mode code of channel 1 |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte selected for write |
| wr_data | input | BYTE_W | Write data |
| rd_sel | input | 2 | Byte selected for read |
| rd_data | output | BYTE_W | Selected count byte |
| flag_clr | input | 2 | Clears overflow flags |
| ovf_flag | output | 2 | Sticky overflow flags |
| t1_tick | output | 1 | One-cycle pulse per channel 1 overflow |
| pin_in | input | 2 | Count pin inputs |
| pin_out | output | 2 | Toggle or PWM level |
| pin_oe | output | 2 | Pin drive enable |

## Verification
On every cycle the assertions check the following: flag stickiness and set-over-clear, the hold of a stopped or frozen channel, the absence of ticks from a frozen channel 1, the PWM pin level against the count bytes, and the toggle register's reset-to-one and flip-on-event rules. The arithmetic of each mode needs the bench's scenarios and its reference model. These cover the prescaler carry, the reload value, split ownership of flag 1, the synchronizer latency of external edges and write-versus-count priority, which play out over many cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      TM_PRE13  = 3'd0,
      TM_FULL16 = 3'd1,
      TM_AUTO8  = 3'd2,
      TM_SPLIT  = 3'd3,
      TM_PWM8   = 3'd6
   } tmr_mode_e;
endpackage

// File: rtl/tmr_pin.sv
module tmr_pin #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic tog_en,
   input  logic pwm_mode,
   input  logic pwm_lvl,
   input  logic evt,
   output logic fall,
   output logic tog_q,
   output logic pin_out,
   output logic pin_oe
);
   localparam int TAPS = SYNC_STAGES + 1;
   logic [TAPS-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[TAPS-2:0], pin_in};
   end

   assign fall = sync_q[TAPS-1] & ~sync_q[TAPS-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog_q <= 1'b1;
      else if (!tog_en) tog_q <= 1'b1;
      else if (evt)     tog_q <= ~tog_q;
   end

   assign pin_oe  = tog_en | pwm_mode;
   assign pin_out = pwm_mode ? pwm_lvl : tog_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int PRESCALE_BITS = 5,
   parameter bit SPLIT_EN      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              inc,
   input  logic              hi_inc,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf,
   output logic              hi_ovf,
   output logic              pwm
);
   localparam int P = PRESCALE_BITS;
   logic [BYTE_W-1:0] lo_n, hi_n;
   logic              split_live;
   logic [P-1:0]      pre;

   generate
      if (SPLIT_EN) begin : g_split
         assign split_live = 1'b1;
      end else begin : g_frozen
         assign split_live = 1'b0;
      end
   endgenerate

   assign pre = lo[P-1:0];

   always_comb begin
      lo_n   = lo;
      hi_n   = hi;
      ovf    = 1'b0;
      hi_ovf = 1'b0;
      if (!(wr_lo || wr_hi)) begin
         unique case (mode)
            TM_PRE13: if (inc) begin
               if (&pre) begin
                  lo_n[P-1:0] = '0;
                  hi_n        = hi + 1'b1;
                  ovf         = &hi;
               end else begin
                  lo_n[P-1:0] = pre + 1'b1;
               end
            end
            TM_FULL16: if (inc) begin
               {hi_n, lo_n} = {hi, lo} + 1'b1;
               ovf          = &{hi, lo};
            end
            TM_AUTO8: if (inc) begin
               lo_n = (&lo) ? hi : lo + 1'b1;
               ovf  = &lo;
            end
            TM_SPLIT: if (split_live) begin
               if (inc) begin
                  lo_n = lo + 1'b1;
                  ovf  = &lo;
               end
               if (hi_inc) begin
                  hi_n   = hi + 1'b1;
                  hi_ovf = &hi;
               end
            end
            TM_PWM8: if (inc) begin
               lo_n = lo + 1'b1;
               ovf  = &lo;
            end
            default: ;
         endcase
      end
      if (wr_lo) lo_n = wr_data;
      if (wr_hi) hi_n = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= lo_n;
         hi <= hi_n;
      end
   end

   assign pwm = lo < hi;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int PRESCALE_BITS = 5,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        run_en,
   input  logic [1:0]        ext_sel,
   input  logic [1:0]        tog_en,
   input  logic [2:0]        mode_t0,
   input  logic [2:0]        mode_t1,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [1:0]        flag_clr,
   output logic [1:0]        ovf_flag,
   output logic              t1_tick,
   input  logic [1:0]        pin_in,
   output logic [1:0]        pin_out,
   output logic [1:0]        pin_oe
);
   localparam int NCH = 2;

   generate
      if (PRESCALE_BITS < 1 || PRESCALE_BITS >= BYTE_W) begin : g_bad_pre
         $error("tmr_pair: PRESCALE_BITS must lie in 1..BYTE_W-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_pair: SYNC_STAGES must be at least 2");
      end
   endgenerate

   tmr_mode_e                     mode_v [NCH];
   logic [NCH-1:0][BYTE_W-1:0]    cnt_lo, cnt_hi;
   logic [NCH-1:0]                ovf, hi_ovf, pwm, fall, inc, wr_ch, set_evt, tog_st;
   logic [NCH-1:0]                hi_inc;
   logic                          split0;

   assign mode_v[0] = tmr_mode_e'(mode_t0);
   assign mode_v[1] = tmr_mode_e'(mode_t1);
   assign split0    = (mode_v[0] == TM_SPLIT);
   assign hi_inc    = {1'b0, run_en[1]};

   assign set_evt[0] = ovf[0];
   assign set_evt[1] = split0 ? hi_ovf[0] : ovf[1];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign wr_ch[ch] = wr_en && (wr_sel[1] == ch[0]);
      assign inc[ch]   = run_en[ch] & (ext_sel[ch] ? (fall[ch] & ~tog_en[ch]) : 1'b1);

      tmr_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_in   (pin_in[ch]),
         .tog_en   (tog_en[ch]),
         .pwm_mode (mode_v[ch] == TM_PWM8),
         .pwm_lvl  (pwm[ch]),
         .evt      (set_evt[ch]),
         .fall     (fall[ch]),
         .tog_q    (tog_st[ch]),
         .pin_out  (pin_out[ch]),
         .pin_oe   (pin_oe[ch])
      );

      tmr_channel #(
         .BYTE_W        (BYTE_W),
         .PRESCALE_BITS (PRESCALE_BITS),
         .SPLIT_EN      (ch == 0)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode_v[ch]),
         .inc     (inc[ch]),
         .hi_inc  (hi_inc[ch]),
         .wr_lo   (wr_ch[ch] && !wr_sel[0]),
         .wr_hi   (wr_ch[ch] &&  wr_sel[0]),
         .wr_data (wr_data),
         .lo      (cnt_lo[ch]),
         .hi      (cnt_hi[ch]),
         .ovf     (ovf[ch]),
         .hi_ovf  (hi_ovf[ch]),
         .pwm     (pwm[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ovf_flag[ch] <= 1'b0;
         else if (set_evt[ch])  ovf_flag[ch] <= 1'b1;
         else if (flag_clr[ch]) ovf_flag[ch] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t1_tick <= 1'b0;
      else        t1_tick <= ovf[1];
   end

   always_comb begin
      unique case (rd_sel)
         2'd0:    rd_data = cnt_lo[0];
         2'd1:    rd_data = cnt_hi[0];
         2'd2:    rd_data = cnt_lo[1];
         default: rd_data = cnt_hi[1];
      endcase
   end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          run_en,
   input logic [1:0]          tog_en,
   input logic [2:0]          mode_t0,
   input logic [2:0]          mode_t1,
   input logic                wr_en,
   input logic [1:0]          wr_sel,
   input logic [1:0]          flag_clr,
   input logic [1:0]          ovf_flag,
   input logic                t1_tick,
   input logic [1:0]          pin_out,
   input logic [1:0]          pin_oe,
   input logic [2*BYTE_W-1:0] cnt0,
   input logic [2*BYTE_W-1:0] cnt1,
   input logic                set0,
   input logic                tog_q0
);
   p_run_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en[0] && !(wr_en && !wr_sel[1]) && mode_t0 != 3'd3) |=> $stable(cnt0));

   p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t1 == 3'd3 && !(wr_en && wr_sel[1])) |=> $stable(cnt1));

   p_frozen_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t1 == 3'd3) |=> !t1_tick);

   p_sticky0_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[0] && !flag_clr[0]) |=> ovf_flag[0]);

   p_sticky1_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[1] && !flag_clr[1]) |=> ovf_flag[1]);

   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set0 |=> ovf_flag[0]);

   p_pwm_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t0 == 3'd6) |-> pin_oe[0]);

   p_pwm_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t0 == 3'd6) |-> (pin_out[0] == (cnt0[BYTE_W-1:0] < cnt0[2*BYTE_W-1:BYTE_W])));

   p_tog_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tog_en[0] |=> tog_q0);

   p_tog_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_en[0] && set0) |=> (tog_q0 != $past(tog_q0)));
endmodule

bind tmr_pair tmr_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .tog_en   (tog_en),
   .mode_t0  (mode_t0),
   .mode_t1  (mode_t1),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .flag_clr (flag_clr),
   .ovf_flag (ovf_flag),
   .t1_tick  (t1_tick),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .cnt0     ({cnt_hi[0], cnt_lo[0]}),
   .cnt1     ({cnt_hi[1], cnt_lo[1]}),
   .set0     (set_evt[0]),
   .tog_q0   (tog_st[0])
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] run_en = '0, ext_sel = '0, tog_en = '0, flag_clr = '0, pin_in = 2'b11;
   logic [2:0] mode_t0 = 3'd5, mode_t1 = 3'd5;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0, rd_sel = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [1:0] ovf_flag, pin_out, pin_oe;
   logic       t1_tick;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   tmr_pair u_tmr_pair (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_sel(ext_sel), .tog_en(tog_en),
      .mode_t0(mode_t0), .mode_t1(mode_t1), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .flag_clr(flag_clr),
      .ovf_flag(ovf_flag), .t1_tick(t1_tick), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model, built from the requirements
   bit [7:0] m_lo [2], m_hi [2];
   bit [1:0] m_flag;
   bit [1:0] m_tog;
   bit       m_tick;
   bit [2:0] m_sync [2];

   function automatic void step(input int md, input bit split_ok, input bit inc, input bit hinc,
                                input bit [7:0] lo, input bit [7:0] hi,
                                output bit [7:0] nl, output bit [7:0] nh,
                                output bit ov, output bit hov);
      nl = lo; nh = hi; ov = 0; hov = 0;
      case (md)
         0: if (inc) begin
            if (lo[4:0] == 5'h1f) begin
               nl[4:0] = 0; nh = hi + 1; ov = (hi == 8'hff);
            end else nl[4:0] = lo[4:0] + 1;
         end
         1: if (inc) begin
            {nh, nl} = {hi, lo} + 16'd1; ov = ({hi, lo} == 16'hffff);
         end
         2: if (inc) begin
            nl = (lo == 8'hff) ? hi : lo + 1; ov = (lo == 8'hff);
         end
         3: if (split_ok) begin
            if (inc)  begin nl = lo + 1; ov = (lo == 8'hff); end
            if (hinc) begin nh = hi + 1; hov = (hi == 8'hff); end
         end
         6: if (inc) begin nl = lo + 1; ov = (lo == 8'hff); end
         default: ;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      bit [7:0] nl [2], nh [2];
      bit ov [2], hov [2], inc [2], wrh [2], setv [2];
      int md [2];
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_sync[c] = 3'b111;
         end
         m_flag = 0; m_tog = 2'b11; m_tick = 0;
      end else begin
         md[0] = mode_t0; md[1] = mode_t1;
         for (int c = 0; c < 2; c++) begin
            inc[c] = run_en[c] && (ext_sel[c] ? (m_sync[c][2] && !m_sync[c][1] && !tog_en[c]) : 1'b1);
            wrh[c] = wr_en && (wr_sel[1] == c[0]);
            step(md[c], c == 0, inc[c] && !wrh[c], (c == 0) && run_en[1] && !wrh[c],
                 m_lo[c], m_hi[c], nl[c], nh[c], ov[c], hov[c]);
            if (wrh[c]) begin
               ov[c] = 0; hov[c] = 0;
               if (wr_sel[0]) nh[c] = wr_data; else nl[c] = wr_data;
            end
         end
         setv[0] = ov[0];
         setv[1] = (md[0] == 3) ? hov[0] : ov[1];
         for (int c = 0; c < 2; c++) begin
            if (setv[c]) m_flag[c] = 1; else if (flag_clr[c]) m_flag[c] = 0;
            if (!tog_en[c]) m_tog[c] = 1; else if (setv[c]) m_tog[c] = ~m_tog[c];
            m_lo[c] = nl[c]; m_hi[c] = nh[c];
            m_sync[c] = {m_sync[c][1:0], pin_in[c]};
         end
         m_tick = ov[1];
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string mode_tag(input int md, input int c);
      case (md)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return (c == 0) ? "R6" : "R7";
         6: return "R9";
         default: return "R7";
      endcase
   endfunction

   task automatic cmp_all();
      int c, md;
      bit [7:0] exp_rd;
      c  = rd_sel[1];
      md = c ? mode_t1 : mode_t0;
      exp_rd = rd_sel[0] ? m_hi[c] : m_lo[c];
      chk(rd_data == exp_rd, {mode_tag(md, c), " count byte"}, rd_data, exp_rd);
      chk(ovf_flag == m_flag, "R11 flags", ovf_flag, m_flag);
      chk(t1_tick == m_tick, "R8 tick", t1_tick, m_tick);
      for (int k = 0; k < 2; k++) begin
         int mk;
         bit eo, eoe;
         mk  = k ? mode_t1 : mode_t0;
         eo  = (mk == 6) ? (m_lo[k] < m_hi[k]) : m_tog[k];
         eoe = tog_en[k] || (mk == 6);
         chk(pin_out[k] == eo,  (mk == 6) ? "R9 pin level" : "R10 pin level", pin_out[k], eo);
         chk(pin_oe[k] == eoe, (mk == 6) ? "R9 pin drive" : "R10 pin drive", pin_oe[k], eoe);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      cmp_all();
   endtask

   task automatic quiet();
      run_en = 0; ext_sel = 0; tog_en = 0; flag_clr = 0; wr_en = 0;
   endtask

   task automatic wr(input bit [1:0] sel, input bit [7:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      cyc();
      wr_en = 0;
   endtask

   task automatic clr_flags();
      flag_clr = 2'b11;
      cyc();
      flag_clr = 0;
   endtask

   task automatic peek(input bit [1:0] sel, input bit [7:0] exp, input string tag);
      rd_sel = sel;
      #1;
      chk(rd_data == exp, tag, rd_data, exp);
   endtask

   function automatic bit [2:0] pick_mode();
      int t;
      t = $urandom_range(0, 5);
      case (t)
         0: return 3'd0;
         1: return 3'd1;
         2: return 3'd2;
         3: return 3'd3;
         4: return 3'd6;
         default: return 3'd5;
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4711));
      repeat (2) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      for (int s = 0; s < 4; s++) peek(s[1:0], 8'h00, "R1 count after reset");
      chk(ovf_flag == 0, "R1 flags", ovf_flag, 0);
      chk(pin_oe == 0, "R1 pin drive", pin_oe, 0);
      chk(pin_out == 2'b11, "R1 pin level", pin_out, 3);
      chk(t1_tick == 0, "R1 tick", t1_tick, 0);
      cyc();

      // R3 prescaler carry into high byte and overflow
      quiet(); mode_t0 = 0;
      wr(2'd1, 8'hff); wr(2'd0, 8'hfe); clr_flags();
      run_en = 2'b01; cyc(); cyc(); run_en = 0;
      peek(2'd0, 8'he0, "R3 low byte keeps upper bits");
      peek(2'd1, 8'h00, "R3 high byte wraps");
      chk(ovf_flag[0] == 1, "R3 overflow flag", ovf_flag[0], 1);
      cyc();

      // R5 reload
      mode_t0 = 2; clr_flags();
      wr(2'd1, 8'hf0); wr(2'd0, 8'hfe);
      run_en = 2'b01; cyc(); cyc(); cyc(); run_en = 0;
      peek(2'd0, 8'hf1, "R5 reload then count");
      peek(2'd1, 8'hf0, "R5 high byte untouched");
      chk(ovf_flag[0] == 1, "R5 overflow flag", ovf_flag[0], 1);
      cyc();

      // R12 write beats count, then counting resumes
      mode_t0 = 1; run_en = 2'b01;
      wr(2'd0, 8'h40);
      peek(2'd0, 8'h40, "R12 write lands without count");
      cyc();
      peek(2'd0, 8'h41, "R12 count resumes");
      run_en = 0; cyc();

      // R2 external falling edges, ignored while stopped
      mode_t0 = 1; wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      ext_sel = 2'b01; run_en = 2'b01;
      repeat (3) begin pin_in[0] = 0; cyc(); cyc(); pin_in[0] = 1; cyc(); cyc(); end
      repeat (3) cyc();
      peek(2'd0, 8'h03, "R2 external edge count");
      run_en = 0;
      repeat (2) begin pin_in[0] = 0; cyc(); cyc(); pin_in[0] = 1; cyc(); cyc(); end
      peek(2'd0, 8'h03, "R2 stopped channel holds");
      ext_sel = 0;

      // R10 toggle output
      wr(2'd1, 8'hff); wr(2'd0, 8'hff); clr_flags();
      tog_en = 2'b01; cyc();
      chk(pin_out[0] == 1, "R10 starts high", pin_out[0], 1);
      chk(pin_oe[0] == 1, "R10 drives pin", pin_oe[0], 1);
      run_en = 2'b01; cyc(); run_en = 0;
      chk(pin_out[0] == 0, "R10 inverts on overflow", pin_out[0], 0);
      tog_en = 0; cyc();

      // R9 PWM duty boundaries
      mode_t0 = 6; wr(2'd1, 8'h00); wr(2'd0, 8'h00); #1;
      chk(pin_out[0] == 0, "R9 zero duty low", pin_out[0], 0);
      wr(2'd1, 8'h80); wr(2'd0, 8'h7f); #1;
      chk(pin_out[0] == 1, "R9 below compare high", pin_out[0], 1);
      wr(2'd0, 8'h80); #1;
      chk(pin_out[0] == 0, "R9 at compare low", pin_out[0], 0);

      // R7 frozen channel 1
      mode_t1 = 3; mode_t0 = 5; run_en = 2'b10;
      wr(2'd2, 8'h12);
      repeat (5) cyc();
      peek(2'd2, 8'h12, "R7 frozen channel holds");
      run_en = 0;

      // R6 split high half owns flag 1
      mode_t0 = 3; mode_t1 = 5; clr_flags();
      wr(2'd1, 8'hfe);
      run_en = 2'b10; cyc(); cyc(); run_en = 0;
      peek(2'd1, 8'h00, "R6 split high wraps");
      chk(ovf_flag == 2'b10, "R6 flag ownership", ovf_flag, 2);
      cyc();

      // R8 channel 1 ticks without setting flag 1 during split
      clr_flags(); mode_t1 = 2; wr(2'd1, 8'h00); wr(2'd3, 8'h00); wr(2'd2, 8'hff);
      run_en = 2'b10; cyc(); run_en = 0;
      chk(t1_tick == 1, "R8 tick pulses", t1_tick, 1);
      chk(ovf_flag[1] == 0, "R8 flag untouched", ovf_flag[1], 0);
      cyc();
      chk(t1_tick == 0, "R8 tick single cycle", t1_tick, 0);

      // constrained random phases
      for (int ph = 0; ph < 12; ph++) begin
         mode_t0 = pick_mode(); mode_t1 = pick_mode();
         for (int n = 0; n < 1500; n++) begin
            cyc();
            run_en   = ($urandom_range(0, 7) != 0) ? 2'b11 : 2'($urandom);
            if ($urandom_range(0, 99) == 0) ext_sel = 2'($urandom);
            if ($urandom_range(0, 199) == 0) tog_en = 2'($urandom);
            pin_in   = 2'($urandom);
            flag_clr = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            wr_en    = ($urandom_range(0, 31) == 0);
            wr_sel   = 2'($urandom);
            wr_data  = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(8'hf8, 8'hff)) : 8'($urandom);
            rd_sel   = 2'($urandom);
         end
      end
      quiet(); cyc();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule